// File: doc/BRIEF.md
# Privileged Segment Address Translator

This block turns a 64-bit virtual address into a physical address for the regions of a 64-bit segmented address space that need no page tables. There are two such regions. The first is the large direct physical window selected by address bits 63:62 = 10. The second is the pair of 32-bit compatibility windows at the very top of the space. The block has no TLB. Every mapped region therefore raises an address error, and so does any address outside these regions.

Each request is also checked against the current privilege level. That level comes from the two status exception bits and the two-bit mode field. The unmapped regions are open only to the most privileged level. A request that is refused reports an address-error code. The code depends on whether the access was a data store or some other kind of access.

A parameter selects between two variants. The default variant registers the result and returns it one cycle after the request strobe, with its own response strobe. The other variant is purely combinational.

Top module: `seg_xlate`

## Requirements
- R1: Current privilege is the top level (2) when `st_exl` or `st_erl` is 1. Otherwise it comes from `st_ksu`: 00 gives top level (2), 01 gives middle level (1), 10 gives lowest level (0), and 11 gives lowest level (0).
- R2: An address with bits 63:62 = 10, accessed at top level, translates to bits 58:0 zero-extended to 64 bits. Bits 61:59 have no effect on the result.
- R3: An address with bits 63:31 all ones and bit 30 = 0, accessed at top level, translates to bits 28:0 zero-extended to 64 bits.
- R4: Any access to the regions of R2 or R3 at a level below the top level is refused.
- R5: An address with bits 63:31 all ones and bit 30 = 1 is refused at every privilege level.
- R6: Any other address with bits 63:62 = 11 is refused at every privilege level.
- R7: Any address with bit 63 = 0 is refused at every privilege level.
- R8: A refused request shows `xlt_ok` = 0, `paddr` = 0 and `exc` = 1. An accepted request shows `xlt_ok` = 1 and `exc` = 0.
- R9: `acc_type` uses this encoding: 00 = fetch, 01 = load, 10 = store, 11 = handled as a load. On a refusal, `exc_code` is 5 for a store and 4 for every other access type.
- R10: In the registered variant, `rsp_vld` and the result appear on the cycle after the clock edge that samples `req_vld`. After a cycle with no request, all outputs are 0.
- R11: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe |
| vaddr | input | 64 | Virtual address |
| acc_type | input | 2 | Access type: 00 fetch, 01 load, 10 store |
| st_exl | input | 1 | Exception-level status bit |
| st_erl | input | 1 | Error-level status bit |
| st_ksu | input | 2 | Mode field |
| rsp_vld | output | 1 | Response strobe |
| paddr | output | 64 | Physical address, 0 when refused |
| xlt_ok | output | 1 | Translation accepted |
| exc | output | 1 | Address error raised |
| exc_code | output | 5 | Error code: 4 for load or fetch, 5 for store |

## Verification
In the default registered variant, every output is due exactly one clock edge after the edge that samples the request. This holds for the response strobe, the physical address, the accept flag and the error code, and it also holds for the all-zero idle state after a cycle without a request.

The bench drives its stimulus on the falling edge and computes the expected result from its own address-range model. It then compares all outputs on the next falling edge, after the intervening rising edge has registered the result. The comparison runs on every cycle, so back-to-back requests, idle gaps and the reset period are all covered.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      PRIV_LOW  = 2'd0,
      PRIV_MID  = 2'd1,
      PRIV_TOP  = 2'd2
   } priv_t;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'b00,
      ACC_LOAD  = 2'b01,
      ACC_STORE = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_t;

   localparam int unsigned DEF_CODE_W     = 5;
   localparam int unsigned DEF_LOAD_CODE  = 4;
   localparam int unsigned DEF_STORE_CODE = 5;

endpackage

// File: rtl/seg_priv_decode.sv
module seg_priv_decode
   import seg_xlate_pkg::*;
(
   input  logic       exl,
   input  logic       erl,
   input  logic [1:0] ksu,
   output priv_t      level
);

   always_comb begin
      if (exl || erl) begin
         level = PRIV_TOP;
      end else begin
         unique case (ksu)
            2'b00:   level = PRIV_TOP;
            2'b01:   level = PRIV_MID;
            default: level = PRIV_LOW;
         endcase
      end
   end

endmodule

// File: rtl/seg_region_decode.sv
module seg_region_decode
   import seg_xlate_pkg::*;
#(
   parameter int unsigned VA_W = 64
)(
   input  logic [VA_W-1:0] va,
   output logic            hit,
   output priv_t           need_lvl,
   output logic [VA_W-1:0] pa
);

   localparam int unsigned WIDE_TOP   = VA_W - 6;
   localparam int unsigned NARROW_TOP = 28;
   localparam int unsigned ONES_LO    = 31;
   localparam int unsigned ONES_HI    = VA_W - 3;
   localparam int unsigned WIN_SEL    = 30;

   logic unused_va;
   assign unused_va = ^{va[VA_W-3:WIDE_TOP+1], va[WIN_SEL-1]};

   always_comb begin
      hit      = 1'b0;
      need_lvl = PRIV_TOP;
      pa       = '0;
      unique case (va[VA_W-1 -: 2])
         2'b10: begin
            hit              = 1'b1;
            pa[WIDE_TOP:0]   = va[WIDE_TOP:0];
         end
         2'b11: begin
            if ((&va[ONES_HI:ONES_LO]) && !va[WIN_SEL]) begin
               hit              = 1'b1;
               pa[NARROW_TOP:0] = va[NARROW_TOP:0];
            end
         end
         default: begin
            hit = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/seg_resolve.sv
module seg_resolve
   import seg_xlate_pkg::*;
#(
   parameter int unsigned VA_W       = 64,
   parameter int unsigned CODE_W     = DEF_CODE_W,
   parameter int unsigned LOAD_CODE  = DEF_LOAD_CODE,
   parameter int unsigned STORE_CODE = DEF_STORE_CODE
)(
   input  logic              req,
   input  logic              hit,
   input  priv_t             need_lvl,
   input  priv_t             cur_lvl,
   input  logic [1:0]        acc,
   input  logic [VA_W-1:0]   pa_in,
   output logic              ok,
   output logic              fault,
   output logic [CODE_W-1:0] code,
   output logic [VA_W-1:0]   pa_out
);

   logic allowed;
   assign allowed = hit && (cur_lvl >= need_lvl);

   always_comb begin
      ok     = 1'b0;
      fault  = 1'b0;
      code   = '0;
      pa_out = '0;
      if (req) begin
         if (allowed) begin
            ok     = 1'b1;
            pa_out = pa_in;
         end else begin
            fault = 1'b1;
            code  = (acc == ACC_STORE) ? CODE_W'(STORE_CODE) : CODE_W'(LOAD_CODE);
         end
      end
   end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int unsigned VA_W       = 64,
   parameter int unsigned CODE_W     = DEF_CODE_W,
   parameter int unsigned LOAD_CODE  = DEF_LOAD_CODE,
   parameter int unsigned STORE_CODE = DEF_STORE_CODE,
   parameter bit          REGISTERED = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic [VA_W-1:0]   vaddr,
   input  logic [1:0]        acc_type,
   input  logic              st_exl,
   input  logic              st_erl,
   input  logic [1:0]        st_ksu,
   output logic              rsp_vld,
   output logic [VA_W-1:0]   paddr,
   output logic              xlt_ok,
   output logic              exc,
   output logic [CODE_W-1:0] exc_code
);

   localparam int unsigned CODE_MAX = (1 << CODE_W) - 1;

   if (VA_W != 64) begin : g_bad_va_w
      $error("seg_xlate: VA_W must be 64");
   end
   if (LOAD_CODE > CODE_MAX || STORE_CODE > CODE_MAX) begin : g_bad_code
      $error("seg_xlate: error codes do not fit CODE_W");
   end

   priv_t            cur_lvl;
   priv_t            need_lvl;
   logic             hit;
   logic [VA_W-1:0]  pa_raw;
   logic             n_ok;
   logic             n_fault;
   logic [CODE_W-1:0] n_code;
   logic [VA_W-1:0]  n_pa;

   seg_priv_decode u_priv (
      .exl   (st_exl),
      .erl   (st_erl),
      .ksu   (st_ksu),
      .level (cur_lvl)
   );

   seg_region_decode #(.VA_W(VA_W)) u_region (
      .va       (vaddr),
      .hit      (hit),
      .need_lvl (need_lvl),
      .pa       (pa_raw)
   );

   seg_resolve #(
      .VA_W       (VA_W),
      .CODE_W     (CODE_W),
      .LOAD_CODE  (LOAD_CODE),
      .STORE_CODE (STORE_CODE)
   ) u_resolve (
      .req      (req_vld),
      .hit      (hit),
      .need_lvl (need_lvl),
      .cur_lvl  (cur_lvl),
      .acc      (acc_type),
      .pa_in    (pa_raw),
      .ok       (n_ok),
      .fault    (n_fault),
      .code     (n_code),
      .pa_out   (n_pa)
   );

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rsp_vld  <= 1'b0;
            paddr    <= '0;
            xlt_ok   <= 1'b0;
            exc      <= 1'b0;
            exc_code <= '0;
         end else begin
            rsp_vld  <= req_vld;
            paddr    <= n_pa;
            xlt_ok   <= n_ok;
            exc      <= n_fault;
            exc_code <= n_code;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk;
      assign rsp_vld  = rst_n && req_vld;
      assign paddr    = rst_n ? n_pa : '0;
      assign xlt_ok   = rst_n && n_ok;
      assign exc      = rst_n && n_fault;
      assign exc_code = rst_n ? n_code : '0;
   end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int unsigned VA_W       = 64,
   parameter int unsigned CODE_W     = 5,
   parameter int unsigned STORE_CODE = 5,
   parameter bit          REGISTERED = 1'b1
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_vld,
   input logic [VA_W-1:0]   vaddr,
   input logic [1:0]        acc_type,
   input logic              rsp_vld,
   input logic [VA_W-1:0]   paddr,
   input logic              xlt_ok,
   input logic              exc,
   input logic [CODE_W-1:0] exc_code
);

   localparam int unsigned PA_HI_LO = VA_W - 5;

   // R8
   fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc |-> (!xlt_ok && paddr == '0 && rsp_vld));

   // R2
   pa_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xlt_ok |-> (paddr[VA_W-1:PA_HI_LO] == '0));

   if (REGISTERED) begin : g_seq
      // R10
      rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         req_vld |=> rsp_vld);
      // R10
      idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !req_vld |=> (!rsp_vld && !xlt_ok && !exc && paddr == '0));
      // R7
      low_half_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_vld && !vaddr[VA_W-1]) |=> exc);
      // R9
      store_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_vld && acc_type == 2'b10) |=> (!exc || exc_code == CODE_W'(STORE_CODE)));
   end else begin : g_comb
      // R10
      rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         req_vld |-> rsp_vld);
      // R7
      low_half_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_vld && !vaddr[VA_W-1]) |-> exc);
      // R9
      store_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_vld && acc_type == 2'b10) |-> (!exc || exc_code == CODE_W'(STORE_CODE)));
   end

endmodule

bind seg_xlate seg_xlate_chk #(
   .VA_W       (VA_W),
   .CODE_W     (CODE_W),
   .STORE_CODE (STORE_CODE),
   .REGISTERED (REGISTERED)
) u_seg_xlate_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_vld  (req_vld),
   .vaddr    (vaddr),
   .acc_type (acc_type),
   .rsp_vld  (rsp_vld),
   .paddr    (paddr),
   .xlt_ok   (xlt_ok),
   .exc      (exc),
   .exc_code (exc_code)
);

// File: tb/test_seg_xlate.sv
`timescale 1ns/1ps
module test_seg_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0;
   logic [63:0] vaddr = '0;
   logic [1:0]  acc_type = '0;
   logic        st_exl = 1'b0;
   logic        st_erl = 1'b0;
   logic [1:0]  st_ksu = '0;
   logic        rsp_vld;
   logic [63:0] paddr;
   logic        xlt_ok;
   logic        exc;
   logic [4:0]  exc_code;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic        e_vld = 1'b0;
   logic [63:0] e_pa = '0;
   logic        e_ok = 1'b0;
   logic        e_exc = 1'b0;
   logic [4:0]  e_code = '0;
   string       e_tag = "R11";

   always #2 clk = ~clk;

   seg_xlate i_seg_xlate (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .vaddr(vaddr),
      .acc_type(acc_type), .st_exl(st_exl), .st_erl(st_erl), .st_ksu(st_ksu),
      .rsp_vld(rsp_vld), .paddr(paddr), .xlt_ok(xlt_ok), .exc(exc),
      .exc_code(exc_code)
   );

   task automatic compare();
      n_cmp++;
      if (rsp_vld !== e_vld || paddr !== e_pa || xlt_ok !== e_ok ||
          exc !== e_exc || exc_code !== e_code) begin
         n_bad++;
         $display("FAIL %s: got vld=%0b pa=%h ok=%0b exc=%0b code=%0d exp vld=%0b pa=%h ok=%0b exc=%0b code=%0d",
                  e_tag, rsp_vld, paddr, xlt_ok, exc, exc_code,
                  e_vld, e_pa, e_ok, e_exc, e_code);
      end
   endtask

   // Behavioural model: privilege as integer, regions as address ranges.
   task automatic model(input bit v, input logic [63:0] a, input logic [1:0] t,
                        input bit x, input bit r, input logic [1:0] k, input string tag);
      int lvl;
      bit grant;
      logic [63:0] pa;
      lvl = (x || r) ? 2 : (k == 2'd0) ? 2 : (k == 2'd1) ? 1 : 0;
      grant = 1'b0;
      pa = '0;
      if (a >= 64'h8000_0000_0000_0000 && a < 64'hC000_0000_0000_0000) begin
         grant = (lvl == 2);
         pa = a & 64'h07FF_FFFF_FFFF_FFFF;
      end else if (a >= 64'hFFFF_FFFF_8000_0000 && a < 64'hFFFF_FFFF_C000_0000) begin
         grant = (lvl == 2);
         pa = a & 64'h0000_0000_1FFF_FFFF;
      end
      e_tag  = tag;
      e_vld  = v;
      e_ok   = v && grant;
      e_exc  = v && !grant;
      e_pa   = (v && grant) ? pa : 64'd0;
      e_code = (v && !grant) ? ((t == 2'b10) ? 5'd5 : 5'd4) : 5'd0;
   endtask

   task automatic step(input bit v, input logic [63:0] a, input logic [1:0] t,
                       input bit x, input bit r, input logic [1:0] k, input string tag);
      @(negedge clk);
      compare();
      req_vld = v; vaddr = a; acc_type = t; st_exl = x; st_erl = r; st_ksu = k;
      model(v, a, t, x, r, k, tag);
   endtask

   task automatic kern(input logic [63:0] a, input logic [1:0] t, input string tag);
      step(1'b1, a, t, 1'b0, 1'b0, 2'b00, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      // R11: outputs held at zero in reset, even with a request present
      repeat (2) step(1'b0, '0, 2'b00, 1'b0, 1'b0, 2'b00, "R11");
      @(negedge clk);
      compare();
      req_vld = 1'b1; vaddr = 64'h8000_0000_0000_1000;
      e_tag = "R11"; e_vld = 0; e_ok = 0; e_exc = 0; e_pa = 0; e_code = 0;
      @(negedge clk);
      compare();
      req_vld = 1'b0;
      rst_n = 1'b1;
      model(1'b0, '0, 2'b00, 1'b0, 1'b0, 2'b00, "R10");

      // R2: wide physical window, ignored bits 61:59
      kern(64'h8000_0000_1234_5678, 2'b01, "R2");
      kern(64'hB800_0000_0000_0ABC, 2'b00, "R2");
      kern(64'h87FF_FFFF_FFFF_FFFF, 2'b10, "R2");
      kern(64'hBFFF_FFFF_FFFF_FFFF, 2'b01, "R2");
      // R3: compatibility windows
      kern(64'hFFFF_FFFF_8000_1000, 2'b01, "R3");
      kern(64'hFFFF_FFFF_BFFF_FFFF, 2'b10, "R3");
      kern(64'hFFFF_FFFF_A000_0040, 2'b00, "R3");
      // R5: upper compatibility windows refused
      kern(64'hFFFF_FFFF_C000_0000, 2'b01, "R5");
      kern(64'hFFFF_FFFF_E000_0010, 2'b10, "R5");
      step(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 1'b1, 1'b0, 2'b00, "R5");
      // R6: other top-quarter addresses refused
      kern(64'hC000_0000_0000_0000, 2'b01, "R6");
      kern(64'hFFFF_FFFF_7FFF_FFFF, 2'b10, "R6");
      kern(64'hFFFF_FFFE_8000_0000, 2'b00, "R6");
      // R7: lower half refused
      kern(64'h4000_0000_0000_0000, 2'b01, "R7");
      kern(64'h0000_0000_0000_0000, 2'b10, "R7");
      kern(64'h7FFF_FFFF_FFFF_FFFF, 2'b00, "R7");
      // R1 and R4: privilege derivation and refusal below top level
      step(1'b1, 64'h8000_0000_0000_0100, 2'b01, 1'b1, 1'b0, 2'b10, "R1");
      step(1'b1, 64'hFFFF_FFFF_8000_0200, 2'b01, 1'b0, 1'b1, 2'b01, "R1");
      step(1'b1, 64'h8000_0000_0000_0300, 2'b01, 1'b0, 1'b0, 2'b01, "R4");
      step(1'b1, 64'hFFFF_FFFF_8000_0400, 2'b10, 1'b0, 1'b0, 2'b10, "R4");
      step(1'b1, 64'h8000_0000_0000_0500, 2'b00, 1'b0, 1'b0, 2'b11, "R4");
      step(1'b1, 64'hFFFF_FFFF_9000_0000, 2'b10, 1'b0, 1'b0, 2'b01, "R4");
      // R9: code per access type, including reserved encoding
      kern(64'h1000, 2'b00, "R9");
      kern(64'h1000, 2'b01, "R9");
      kern(64'h1000, 2'b10, "R9");
      kern(64'h1000, 2'b11, "R9");
      // R8: refusal clears address even for a valid-looking window
      step(1'b1, 64'h8000_0000_FFFF_FFFF, 2'b10, 1'b0, 1'b0, 2'b10, "R8");
      // R10: idle gaps between requests
      step(1'b0, 64'h8000_0000_0000_0001, 2'b01, 1'b0, 1'b0, 2'b00, "R10");
      kern(64'h8000_0000_0000_0002, 2'b01, "R10");
      step(1'b0, 64'h0, 2'b10, 1'b0, 1'b0, 2'b00, "R10");
      step(1'b0, 64'h0, 2'b10, 1'b0, 1'b0, 2'b00, "R10");
      // Mixed sweep
      for (int i = 0; i < 64; i++) begin
         logic [63:0] a;
         a = {i[1:0], 62'h0} | (64'h1 << (i % 60)) | 64'(i * 997);
         if (i % 5 == 0) a = 64'hFFFF_FFFF_8000_0000 | 64'(i * 4099);
         step(i % 7 != 3, a, 2'(i), i[3] & i[0], 1'b0, 2'(i >> 2), "R10");
      end
      step(1'b0, '0, 2'b00, 1'b0, 1'b0, 2'b00, "R10");
      @(negedge clk);
      compare();
      finish_run();
   end

endmodule